// File: doc/BRIEF.md
# Two-Agent Snooping Write-Through Cache Pair

This block holds two private, direct-mapped, write-through caches, one for each of two processors. Both caches share a single bus to a common memory model. Any line held by either cache stays coherent with memory through invalidation. Every processor write goes out on the shared bus, and memory is updated at once. The opposite cache watches every bus transaction. When it sees a foreign write whose index and tag match a line it holds, it drops that line on the same clock edge. Its next read of that address therefore misses and fetches the current value from memory.

A processor raises its request and holds it until a one-cycle done pulse comes back, then drops it. Read hits are answered locally one cycle after the request is taken. Read misses and all writes wait for the bus. The bus performs one single-cycle transaction per clock and is granted by an alternating-priority arbiter. A read miss fills the line. A write updates the writer's own copy if it is present and never allocates on a miss. Because memory always holds the latest data, every miss is serviced from memory.

Top module: `snoop_coherent_pair`

## Requirements
- R1: While reset is active and after it is released, no done pulse and no bus transaction appear until a request is made, and every line of both caches starts invalid, so the first read of any address misses.
- R2: A read whose index and tag match a valid local line completes with done and hit high one cycle after the request is taken, returns the stored data, and causes no bus transaction.
- R3: A read miss drives one bus transaction with bus_write low, the requester's number on bus_owner and the full address on bus_addr, returns the memory value with hit low, and leaves that line valid in the requesting cache.
- R4: Every write, hit or miss, drives one bus transaction with bus_write high and updates memory with the written data.
- R5: A writer that holds the line keeps it valid and updated with the new data, while a write miss does not allocate, so the writer's next read of that address misses.
- R6: A foreign write whose address has the index (bits 2:0) and tag (bits 5:3) of a valid line in the other cache invalidates that line on the edge that ends the bus cycle, so the next read there misses and returns the newly written value.
- R7: A foreign write to an address with the same index but a different tag leaves the other cache's line valid, and the line still hits.
- R8: A bus read never changes the valid state of the other cache.
- R9: At most one transaction is granted per cycle. When both caches request in the same cycle, the one not granted most recently wins, and after reset processor 0 wins the first tie. All agents see writes to one address in grant order.
- R10: A read hit taken on the same edge that a foreign invalidate clears that line is ordered before the write and returns the old data, and the following read misses and returns the new data.
- R11: The sequence "P0 reads X, P1 reads X, P0 writes 1 to X, P1 reads X" produces bus activity read miss, read miss, write, read miss, and P1 finally reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 2 | Request per processor, held until its done pulse |
| cpu_we | input | 2 | Write (1) or read (0) per processor |
| cpu_addr | input | 2*ADDR_W | Word address per processor, processor n in slice n |
| cpu_wdata | input | 2*DATA_W | Write data per processor |
| cpu_done | output | 2 | One-cycle completion pulse per processor |
| cpu_hit | output | 2 | With done: read served from the local copy |
| cpu_rdata | output | 2*DATA_W | Read data per processor, valid with done |
| bus_valid | output | 1 | A bus transaction occupies this cycle |
| bus_write | output | 1 | Transaction is a write (and invalidate broadcast) |
| bus_owner | output | 1 | Processor number that owns the transaction |
| bus_addr | output | ADDR_W | Address on the shared bus |

## Verification
Two collisions matter most. The first is a local read lookup in one cache on the same edge that a snooped invalidate clears that very line. The bench provokes it by issuing a write on processor 0 and, one cycle later, a read of the same address on processor 1. It then expects the old value with a hit, followed by a miss that returns the new value. The second is both caches wanting the bus in one cycle. The bench starts two misses, and later two writes to one address, on the same edge. It predicts the winner from its own record of the last grant and judges the bus order and the value both processors read back afterwards.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } cache_state_e;
endpackage

// File: rtl/snoop_cache.sv
module snoop_cache
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int AGENT  = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic                     done,
  output logic                     hit,
  output logic [DATA_W-1:0]        rdata,
  output logic                     bus_req,
  output logic [ADDR_W-1:0]        req_addr,
  output logic                     req_write,
  output logic [DATA_W-1:0]        req_wdata,
  input  logic                     bus_gnt,
  input  logic                     bus_valid,
  input  logic                     bus_owner,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [(1<<IDX_W)-1:0]    valid_vec
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic SELF = AGENT[0];

  cache_state_e            state_q, state_d;
  logic [ADDR_W-1:0]       addr_q;
  logic                    we_q;
  logic [DATA_W-1:0]       wdata_q;
  logic [DATA_W-1:0]       rdata_q, rdata_d;
  logic                    hit_q, hit_d;
  logic [LINES-1:0]        valid_q, valid_d;
  logic [TAG_W-1:0]        tag_q  [LINES];
  logic [DATA_W-1:0]       data_q [LINES];

  logic [IDX_W-1:0] in_idx, lat_idx, snp_idx;
  logic [TAG_W-1:0] in_tag, lat_tag, snp_tag;
  logic             in_hit, lat_hit, snoop_kill;
  logic             cap_en, fill_en, upd_en;

  assign in_idx  = addr[IDX_W-1:0];
  assign in_tag  = addr[ADDR_W-1:IDX_W];
  assign lat_idx = addr_q[IDX_W-1:0];
  assign lat_tag = addr_q[ADDR_W-1:IDX_W];
  assign snp_idx = bus_addr[IDX_W-1:0];
  assign snp_tag = bus_addr[ADDR_W-1:IDX_W];

  // lookups: processor side, pending request, and bus snoop
  assign in_hit     = valid_q[in_idx] && (tag_q[in_idx] == in_tag);
  assign lat_hit    = valid_q[lat_idx] && (tag_q[lat_idx] == lat_tag);
  assign snoop_kill = bus_valid && bus_write && (bus_owner != SELF) &&
                      valid_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

  assign cap_en  = (state_q == ST_IDLE) && req;
  assign fill_en = bus_gnt && !we_q;
  assign upd_en  = bus_gnt && we_q && lat_hit;

  always_comb begin
    state_d = state_q;
    rdata_d = rdata_q;
    hit_d   = hit_q;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (!we && in_hit) begin
            state_d = ST_RESP;
            rdata_d = data_q[in_idx];
            hit_d   = 1'b1;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (bus_gnt) begin
          state_d = ST_RESP;
          hit_d   = 1'b0;
          rdata_d = we_q ? rdata_q : mem_rdata;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    valid_d = valid_q;
    if (snoop_kill) valid_d[snp_idx] = 1'b0;
    if (fill_en)    valid_d[lat_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= '0;
      rdata_q <= '0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      rdata_q <= rdata_d;
      hit_q   <= hit_d;
      if (cap_en) begin
        addr_q  <= addr;
        we_q    <= we;
        wdata_q <= wdata;
      end
    end
  end

  // tag and data arrays carry no reset; valid bits qualify them
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[lat_idx]  <= lat_tag;
      data_q[lat_idx] <= mem_rdata;
    end else if (upd_en) begin
      data_q[lat_idx] <= wdata_q;
    end
  end

  assign done      = (state_q == ST_RESP);
  assign hit       = hit_q;
  assign rdata     = rdata_q;
  assign bus_req   = (state_q == ST_WAIT);
  assign req_addr  = addr_q;
  assign req_write = we_q;
  assign req_wdata = wdata_q;
  assign valid_vec = valid_q;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  // fav_q names the agent that wins the next tie
  logic fav_q, fav_d;

  always_comb begin
    if (req == 2'b11) gnt = fav_q ? 2'b10 : 2'b01;
    else              gnt = req;
  end

  always_comb begin
    fav_d = fav_q;
    if (gnt[0])      fav_d = 1'b1;
    else if (gnt[1]) fav_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fav_q <= 1'b0;
    else        fav_q <= fav_d;
  end
endmodule

// File: rtl/shared_mem.sv
module shared_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/snoop_coherent_pair.sv
module snoop_coherent_pair #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cpu_req,
  input  logic [1:0]            cpu_we,
  input  logic [2*ADDR_W-1:0]   cpu_addr,
  input  logic [2*DATA_W-1:0]   cpu_wdata,
  output logic [1:0]            cpu_done,
  output logic [1:0]            cpu_hit,
  output logic [2*DATA_W-1:0]   cpu_rdata,
  output logic                  bus_valid,
  output logic                  bus_write,
  output logic                  bus_owner,
  output logic [ADDR_W-1:0]     bus_addr
);
  localparam int LINES  = 1 << IDX_W;
  localparam int AGENTS = 2;

  logic              rst_meta, rst_n_s;
  logic [1:0]        breq, bgnt;
  logic [ADDR_W-1:0] raddr  [AGENTS];
  logic [DATA_W-1:0] rwdata [AGENTS];
  logic [1:0]        rwrite;
  logic [LINES-1:0]  vvec   [AGENTS];
  logic [LINES-1:0]  vvec0, vvec1;
  logic [DATA_W-1:0] bus_wdata, mem_rdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  for (genvar g = 0; g < AGENTS; g++) begin : g_agent
    snoop_cache #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .AGENT(g)
    ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .req       (cpu_req[g]),
      .we        (cpu_we[g]),
      .addr      (cpu_addr[g*ADDR_W +: ADDR_W]),
      .wdata     (cpu_wdata[g*DATA_W +: DATA_W]),
      .done      (cpu_done[g]),
      .hit       (cpu_hit[g]),
      .rdata     (cpu_rdata[g*DATA_W +: DATA_W]),
      .bus_req   (breq[g]),
      .req_addr  (raddr[g]),
      .req_write (rwrite[g]),
      .req_wdata (rwdata[g]),
      .bus_gnt   (bgnt[g]),
      .bus_valid (bus_valid),
      .bus_owner (bus_owner),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .mem_rdata (mem_rdata),
      .valid_vec (vvec[g])
    );
  end

  assign vvec0 = vvec[0];
  assign vvec1 = vvec[1];

  bus_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n_s),
    .req   (breq),
    .gnt   (bgnt)
  );

  assign bus_valid = |bgnt;
  assign bus_owner = bgnt[1];
  assign bus_addr  = bgnt[1] ? raddr[1]  : raddr[0];
  assign bus_wdata = bgnt[1] ? rwdata[1] : rwdata[0];
  assign bus_write = bus_valid && (bgnt[1] ? rwrite[1] : rwrite[0]);

  shared_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr_en (bus_write),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (mem_rdata)
  );
endmodule

// File: rtl/snoop_coherent_pair_chk.sv
module snoop_coherent_pair_chk #(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic                   bus_owner,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [1:0]             arb_req,
  input logic [1:0]             cpu_done,
  input logic [1:0]             cpu_hit,
  input logic [1:0]             cpu_we,
  input logic [(1<<IDX_W)-1:0]  valid0,
  input logic [(1<<IDX_W)-1:0]  valid1
);
  // granted owner must be a waiting requester
  assert_owner_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> arb_req[bus_owner]);

  // a tie won by agent 0 is followed by a grant to agent 1
  assert_alternate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_owner && arb_req == 2'b11) |=> (bus_valid && bus_owner));

  // a line of cache 1 drops only after a write owned by agent 0
  assert_drop_cause1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(valid1) & ~valid1)) |-> $past(bus_valid && bus_write && !bus_owner));

  assert_drop_cause0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(valid0) & ~valid0)) |-> $past(bus_valid && bus_write && bus_owner));

  // a foreign bus read leaves the other cache's valid bits alone
  assert_read_keeps1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !bus_owner) |=> $stable(valid1));

  assert_read_keeps0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_owner) |=> $stable(valid0));

  // a read miss leaves its line valid
  assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !bus_owner) |=> valid0[$past(bus_addr[IDX_W-1:0])]);

  // a local hit had no bus cycle of its own just before
  assert_hit_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done[0] && cpu_hit[0]) |-> !$past(bus_valid && !bus_owner));

  // every completed write went over the bus
  assert_write_on_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done[1] && cpu_we[1]) |-> $past(bus_valid && bus_write && bus_owner));
endmodule

bind snoop_coherent_pair snoop_coherent_pair_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_owner (bus_owner),
  .bus_addr  (bus_addr),
  .arb_req   (breq),
  .cpu_done  (cpu_done),
  .cpu_hit   (cpu_hit),
  .cpu_we    (cpu_we),
  .valid0    (vvec0),
  .valid1    (vvec1)
);

// File: tb/snoop_coherent_pair_test.sv
`timescale 1ns/1ps
module snoop_coherent_pair_test;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic [1:0]    cpu_req, cpu_we;
  logic [AW-1:0] a_drv [2];
  logic [DW-1:0] d_drv [2];
  logic [1:0]    cpu_done, cpu_hit;
  logic [2*DW-1:0] cpu_rdata;
  logic          bus_valid, bus_write, bus_owner;
  logic [AW-1:0] bus_addr;

  snoop_coherent_pair uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr({a_drv[1], a_drv[0]}), .cpu_wdata({d_drv[1], d_drv[0]}),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_owner(bus_owner),
    .bus_addr(bus_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // scoreboard queues: response {we, hit, rdata}, bus {write, owner, addr}
  logic [17:0] rq0 [$];
  logic [17:0] rq1 [$];
  string       rt0 [$];
  string       rt1 [$];
  logic [7:0]  bq  [$];
  string       bt  [$];

  // reference state built from the requirements
  logic [DW-1:0] m_mem [64];
  bit            mv [2][8];
  logic [2:0]    mt [2][8];
  logic [DW-1:0] md [2][8];
  int            fav;

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void push_resp(int c, logic [17:0] it, string tag);
    if (c == 0) begin rq0.push_back(it); rt0.push_back(tag); end
    else        begin rq1.push_back(it); rt1.push_back(tag); end
  endfunction

  function automatic void model_op(int c, bit we, logic [AW-1:0] a, logic [DW-1:0] wd, string tag);
    int ix = int'(a[2:0]);
    logic [2:0] tg = a[5:3];
    int o = 1 - c;
    bit h = mv[c][ix] && (mt[c][ix] == tg);
    if (!we && h) begin
      push_resp(c, {1'b0, 1'b1, md[c][ix]}, tag);
      return;
    end
    bq.push_back({we, c[0], a});
    bt.push_back(tag);
    fav = (c == 0) ? 1 : 0;
    if (!we) begin
      mv[c][ix] = 1'b1; mt[c][ix] = tg; md[c][ix] = m_mem[a];
      push_resp(c, {1'b0, 1'b0, m_mem[a]}, tag);
    end else begin
      m_mem[a] = wd;
      if (h) md[c][ix] = wd;
      if (mv[o][ix] && mt[o][ix] == tg) mv[o][ix] = 1'b0;
      push_resp(c, {1'b1, 1'b0, 16'h0}, tag);
    end
  endfunction

  task automatic issue(int c, bit we, logic [AW-1:0] a, logic [DW-1:0] wd);
    @(negedge clk);
    cpu_we[c] = we; a_drv[c] = a; d_drv[c] = wd; cpu_req[c] = 1'b1;
    do @(negedge clk); while (!cpu_done[c]);
    cpu_req[c] = 1'b0;
  endtask

  task automatic op(int c, bit we, logic [AW-1:0] a, logic [DW-1:0] wd, string tag);
    model_op(c, we, a, wd, tag);
    issue(c, we, a, wd);
  endtask

  // both agents start on the same edge; model follows the tie winner
  task automatic pair(bit we0, logic [AW-1:0] a0, logic [DW-1:0] w0,
                      bit we1, logic [AW-1:0] a1, logic [DW-1:0] w1, string tag);
    if (fav == 0) begin
      model_op(0, we0, a0, w0, tag); model_op(1, we1, a1, w1, tag);
    end else begin
      model_op(1, we1, a1, w1, tag); model_op(0, we0, a0, w0, tag);
    end
    fork
      issue(0, we0, a0, w0);
      issue(1, we1, a1, w1);
    join
  endtask

  // response monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (cpu_done[c]) begin
          logic [17:0] e;
          string tg;
          if ((c == 0 && rq0.size() == 0) || (c == 1 && rq1.size() == 0)) begin
            check(1'b0, "R2", $sformatf("unexpected done cpu%0d", c), 32'(cpu_done), 32'h0);
          end else begin
            if (c == 0) begin e = rq0.pop_front(); tg = rt0.pop_front(); end
            else        begin e = rq1.pop_front(); tg = rt1.pop_front(); end
            check(cpu_hit[c] == e[16], tg, $sformatf("hit cpu%0d", c), 32'(cpu_hit[c]), 32'(e[16]));
            if (!e[17])
              check(cpu_rdata[c*DW +: DW] == e[15:0], tg, $sformatf("rdata cpu%0d", c),
                    32'(cpu_rdata[c*DW +: DW]), 32'(e[15:0]));
          end
        end
      end
    end
  end

  // bus monitor
  always @(negedge clk) begin
    if (rst_n && bus_valid) begin
      if (bq.size() == 0) begin
        check(1'b0, "R9", "unexpected bus cycle", {24'h0, bus_write, bus_owner, bus_addr}, 32'h0);
      end else begin
        logic [7:0] e;
        string tg;
        e = bq.pop_front(); tg = bt.pop_front();
        check({bus_write, bus_owner, bus_addr} == e, tg, "bus write/owner/addr",
              {24'h0, bus_write, bus_owner, bus_addr}, {24'h0, e});
      end
    end
  end

  task automatic run_all();
    // R11: stated sequence with X = 0x0A
    op(0, 1'b0, 6'h0A, 16'h0, "R11");
    op(1, 1'b0, 6'h0A, 16'h0, "R11");
    op(0, 1'b1, 6'h0A, 16'h0001, "R11");
    op(1, 1'b0, 6'h0A, 16'h0, "R11");
    // R5: writer kept its copy updated, so it hits (R2)
    op(0, 1'b0, 6'h0A, 16'h0, "R5");
    op(0, 1'b0, 6'h0A, 16'h0, "R2");
    // R7: same index, other tag written by cpu0
    op(0, 1'b1, 6'h12, 16'h0055, "R4");
    op(1, 1'b0, 6'h0A, 16'h0, "R7");
    // R5: write miss did not allocate
    op(0, 1'b0, 6'h12, 16'h0, "R5");
    // R8: bus read by cpu0 leaves cpu1's copy
    op(0, 1'b0, 6'h0A, 16'h0, "R3");
    op(1, 1'b0, 6'h0A, 16'h0, "R8");
    // R6: foreign write invalidates, next read fetches new value
    op(1, 1'b1, 6'h0A, 16'h00C3, "R6");
    op(0, 1'b0, 6'h0A, 16'h0, "R6");
    op(1, 1'b0, 6'h0A, 16'h0, "R6");
    // R10: cpu1 lookup on the edge that kills its line
    model_op(1, 1'b0, 6'h0A, 16'h0, "R10");
    model_op(0, 1'b1, 6'h0A, 16'h0007, "R10");
    fork
      issue(0, 1'b1, 6'h0A, 16'h0007);
      begin @(negedge clk); issue(1, 1'b0, 6'h0A, 16'h0); end
    join
    op(1, 1'b0, 6'h0A, 16'h0, "R10");
    // R9: simultaneous misses, writes to one address, then reads of it
    pair(1'b0, 6'h20, 16'h0, 1'b0, 6'h21, 16'h0, "R9");
    pair(1'b1, 6'h30, 16'h1111, 1'b1, 6'h30, 16'h2222, "R9");
    pair(1'b0, 6'h30, 16'h0, 1'b0, 6'h30, 16'h0, "R9");
    pair(1'b1, 6'h05, 16'h0A0A, 1'b0, 6'h0D, 16'h0, "R9");
    // mixed traffic on a small address set
    for (int i = 0; i < 60; i++) begin
      int c = int'($urandom % 2);
      bit w = ($urandom % 3) == 0;
      logic [AW-1:0] a = {2'b00, 1'($urandom % 2), 2'b00, 1'($urandom % 2)};
      op(c, w, a, 16'($urandom), "R6");
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_req = '0; cpu_we = '0;
    a_drv[0] = '0; a_drv[1] = '0; d_drv[0] = '0; d_drv[1] = '0;
    fav = 0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) begin mv[c][i] = 1'b0; mt[c][i] = '0; md[c][i] = '0; end
    repeat (3) @(negedge clk);
    check(cpu_done == 2'b00 && bus_valid == 1'b0, "R1", "quiet in reset",
          {30'h0, cpu_done}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cpu_done == 2'b00 && bus_valid == 1'b0, "R1", "quiet after reset",
          {30'h0, cpu_done}, 32'h0);
    // R1: first reads miss in both caches
    op(0, 1'b0, 6'h01, 16'h0, "R1");
    op(1, 1'b0, 6'h02, 16'h0, "R1");
    fork : run_or_timeout
      run_all();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
      end
    join_any
    disable run_or_timeout;
    check(rq0.size() == 0 && rq1.size() == 0, "R2", "responses left",
          32'(rq0.size() + rq1.size()), 32'h0);
    check(bq.size() == 0, "R9", "bus cycles left", 32'(bq.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule